// File: doc/BRIEF.md
# Framed DDR serial link transmitter

This block sends one frame at a time over a two-wire link made of a clock line and a data line. Data moves on both edges of the link clock, so each full clock pulse carries two bits. Each bit is held for `DIV` system clock cycles. The link clock is therefore the system clock divided by `2*DIV`.

A host loads the frame description on its inputs and pulses `start_i`. The block captures every input in that cycle and raises `busy_o`. It then walks a fixed phase sequence:

1. Optional flush run of ones.
2. Start pattern.
3. Frame type.
4. For data frames only: a user byte, the data words read from an external word buffer, and a CRC byte.
5. A 4-bit tag.
6. End pattern.
7. Optional trailing run of ones.

When the last bit has been sent, the lines return high, `busy_o` falls and `done_o` pulses. A compatibility input removes both runs of ones, which gives a shorter frame.

The word buffer is read combinationally: `buf_data_i` must show the word at `buf_addr_o` in the same cycle. The buffer contents must stay fixed while `busy_o` is high.

Top module: `ltx_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `lnk_clk_o` and `lnk_dat_o` are both 1 and `busy_o` is 0.
- R2: When the captured `compat_i` is 0, the frame opens with 4 bits of 1 and closes with 4 bits of 1 after the end pattern. When it is 1, both of these runs are absent.
- R3: After the opening run (or first, in compatibility mode), the bits 1,0,0,1 are sent, followed by the 4-bit type code, MSB first.
- R4: Type codes 0x4 to 0xC are data frames. They send the 8-bit user byte, MSB first, and then N 16-bit words, each MSB first, read from buffer addresses 0 upward. N is 1, 2, 4, 6, 8, 10, 12 or 16 for codes 0x4 to 0xB, and `len_m1_i`+1 for code 0xC.
- R5: Any other type code (0x0 ping, 0x1 error, 0x2, 0x3, 0xD to 0xF) sends no user byte, no words and no CRC: the tag follows the type code directly.
- R6: In a data frame, the byte after the last word is sent MSB first. It is the CRC-8 of the words (polynomial 0x07, initial value 0x00, bits taken MSB first, word 0 first) when `sw_crc_sel_i` was 0, and `sw_crc_i` when it was 1.
- R7: The 4-bit tag, MSB first, is `ping_tag_i` for type 0x0 and `dtag_i` for every other type.
- R8: After the tag, the bits 0,1,1,0 are sent. Nothing is sent beyond the end pattern and the closing run of R2.
- R9: Bit k of a frame is driven for exactly `DIV` cycles. During it, `lnk_clk_o` is 0 for even k and 1 for odd k, so the data line changes only together with a link clock edge. The first bit appears in the cycle after `start_i` is taken.
- R10: `busy_o` rises in the cycle after an accepted start and stays high until the cycle in which the lines return high. `done_o` is high for exactly that one cycle. A `start_i` pulse while `busy_o` is high is ignored.
- R11: All frame inputs are captured with the accepted start. Changing them during a frame has no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken when idle |
| ftype_i | input | 4 | Frame type code |
| udata_i | input | 8 | User byte for data frames |
| dtag_i | input | 4 | Tag for all non-ping frames |
| ping_tag_i | input | 4 | Tag for ping frames |
| len_m1_i | input | 4 | Word count minus one for type 0xC |
| sw_crc_sel_i | input | 1 | 1 selects `sw_crc_i` as the CRC byte |
| sw_crc_i | input | 8 | Software-supplied CRC byte |
| compat_i | input | 1 | 1 drops the opening and closing runs of ones |
| buf_addr_o | output | 4 | Word buffer read address |
| buf_data_i | input | WORD_W | Word at `buf_addr_o`, same cycle |
| lnk_clk_o | output | 1 | Link clock line |
| lnk_dat_o | output | 1 | Link data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The bench targets the points where the frame length changes:
- ping and error frames, which skip the payload;
- the shortest and longest fixed word counts;
- the variable-length code;
- compatibility mode, which drops both runs of ones.

A design that counted words wrongly, or read the buffer one address late, would send a shifted or repeated word and a wrong CRC. An off-by-one in a field counter would move every later bit by one position, which would also flip the clock parity seen at each bit.

The bench also selects the software CRC byte and takes the ping tag for type 0x0. During one frame it changes every input and pulses start again. A design that did not capture its inputs, or that restarted while busy, would change the stream or the frame length.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOF,
        PH_TYP,
        PH_UDT,
        PH_DAT,
        PH_CRC,
        PH_TAG,
        PH_EOF,
        PH_PST
    } phase_e;

    localparam logic [3:0] SOF_PAT    = 4'b1001;
    localparam logic [3:0] EOF_PAT    = 4'b0110;
    localparam logic [3:0] TYPE_PING  = 4'h0;
    localparam logic [3:0] TYPE_VARL  = 4'hC;
    localparam logic [7:0] CRC_POLY   = 8'h07;
    localparam int         MAX_WORDS  = 16;
    localparam int         AW         = $clog2(MAX_WORDS);

    typedef struct packed {
        logic [3:0] ftype;
        logic [7:0] udata;
        logic [3:0] tag;
        logic [3:0] last;
        logic       data;
        logic       sw_sel;
        logic [7:0] sw_crc;
        logic       compat;
    } cfg_t;

    function automatic logic carries_data(input logic [3:0] t);
        return (t >= 4'h4) && (t <= TYPE_VARL);
    endfunction

    // index of the final word for a data frame type
    function automatic logic [3:0] last_index(input logic [3:0] t, input logic [3:0] lm1);
        case (t)
            4'h4:    return 4'd0;
            4'h5:    return 4'd1;
            4'h6:    return 4'd3;
            4'h7:    return 4'd5;
            4'h8:    return 4'd7;
            4'h9:    return 4'd9;
            4'hA:    return 4'd11;
            4'hB:    return 4'd15;
            4'hC:    return lm1;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/ltx_tick_gen.sv
module ltx_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || !run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/ltx_crc8.sv
module ltx_crc8 #(
    parameter int         DW   = 16,
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0]    crc_i,
    input  logic [DW-1:0] dat_i,
    output logic [7:0]    crc_o
);
    always_comb begin
        logic [7:0] c;
        logic       fb;
        c = crc_i;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = c[7] ^ dat_i[i];
            c  = {c[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
        end
        crc_o = c;
    end
endmodule

// File: rtl/ltx_frame_tx.sv
module ltx_frame_tx
    import ltx_pkg::*;
#(
    parameter int DIV    = 2,
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [3:0]        ftype_i,
    input  logic [7:0]        udata_i,
    input  logic [3:0]        dtag_i,
    input  logic [3:0]        ping_tag_i,
    input  logic [3:0]        len_m1_i,
    input  logic              sw_crc_sel_i,
    input  logic [7:0]        sw_crc_i,
    input  logic              compat_i,
    output logic [AW-1:0]     buf_addr_o,
    input  logic [WORD_W-1:0] buf_data_i,
    output logic              lnk_clk_o,
    output logic              lnk_dat_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int LW = $clog2(WORD_W) + 1;

    typedef struct packed {
        phase_e            phase;
        logic [LW-1:0]     left;
        logic [AW-1:0]     widx;
        logic [WORD_W-1:0] shf;
        logic [7:0]        crc;
        logic              lclk;
        logic              busy;
        logic              done;
        cfg_t              cfg;
    } st_t;

    st_t        s_d, s_q;
    logic       tick;
    logic       clear;
    logic [7:0] crc_nxt;

    ltx_tick_gen #(.DIV(DIV)) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (s_q.busy),
        .clear_i (clear),
        .tick_o  (tick)
    );

    ltx_crc8 #(.DW(WORD_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (s_q.crc),
        .dat_i (buf_data_i),
        .crc_o (crc_nxt)
    );

    // the word loaded next: 0 before the payload, current+1 inside it
    assign buf_addr_o = (s_q.phase == PH_DAT) ? AW'(s_q.widx + 1'b1) : '0;

    // returns {bit count, MSB-aligned value padded with ones}
    function automatic logic [LW+WORD_W-1:0] field_of(input phase_e ph, input cfg_t c,
                                                      input logic [WORD_W-1:0] w,
                                                      input logic [7:0] hw_crc);
        logic [WORD_W-1:0] v;
        logic [LW-1:0]     n;
        v = '1;
        n = LW'(4);
        case (ph)
            PH_SOF: v[WORD_W-1 -: 4] = SOF_PAT;
            PH_TYP: v[WORD_W-1 -: 4] = c.ftype;
            PH_UDT: begin
                v[WORD_W-1 -: 8] = c.udata;
                n = LW'(8);
            end
            PH_DAT: begin
                v = w;
                n = LW'(WORD_W);
            end
            PH_CRC: begin
                v[WORD_W-1 -: 8] = c.sw_sel ? c.sw_crc : hw_crc;
                n = LW'(8);
            end
            PH_TAG: v[WORD_W-1 -: 4] = c.tag;
            PH_EOF: v[WORD_W-1 -: 4] = EOF_PAT;
            default: v = '1;
        endcase
        return {n, v};
    endfunction

    always_comb begin
        cfg_t   cn;
        phase_e np;
        s_d        = s_q;
        s_d.done   = 1'b0;
        clear      = 1'b0;
        np         = PH_IDLE;
        cn         = s_q.cfg;
        if (!s_q.busy) begin
            if (start_i) begin
                cn.ftype  = ftype_i;
                cn.udata  = udata_i;
                cn.tag    = (ftype_i == TYPE_PING) ? ping_tag_i : dtag_i;
                cn.last   = last_index(ftype_i, len_m1_i);
                cn.data   = carries_data(ftype_i);
                cn.sw_sel = sw_crc_sel_i;
                cn.sw_crc = sw_crc_i;
                cn.compat = compat_i;
                s_d.cfg   = cn;
                s_d.phase = compat_i ? PH_SOF : PH_PRE;
                {s_d.left, s_d.shf} = field_of(s_d.phase, cn, buf_data_i, 8'h00);
                s_d.widx  = '0;
                s_d.crc   = 8'h00;
                s_d.lclk  = 1'b0;
                s_d.busy  = 1'b1;
                clear     = 1'b1;
            end
        end else if (tick) begin
            s_d.lclk = ~s_q.lclk;
            if (s_q.left != LW'(1)) begin
                s_d.left = s_q.left - 1'b1;
                s_d.shf  = {s_q.shf[WORD_W-2:0], 1'b1};
            end else begin
                case (s_q.phase)
                    PH_PRE:  np = PH_SOF;
                    PH_SOF:  np = PH_TYP;
                    PH_TYP:  np = s_q.cfg.data ? PH_UDT : PH_TAG;
                    PH_UDT:  np = PH_DAT;
                    PH_DAT:  np = (s_q.widx == s_q.cfg.last) ? PH_CRC : PH_DAT;
                    PH_CRC:  np = PH_TAG;
                    PH_TAG:  np = PH_EOF;
                    PH_EOF:  np = s_q.cfg.compat ? PH_IDLE : PH_PST;
                    default: np = PH_IDLE;
                endcase
                s_d.phase = np;
                if (np == PH_IDLE) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.lclk = 1'b1;
                    s_d.shf  = '1;
                    s_d.left = '0;
                end else begin
                    {s_d.left, s_d.shf} = field_of(np, s_q.cfg, buf_data_i, s_q.crc);
                    if (np == PH_DAT) begin
                        s_d.crc = crc_nxt;
                        if (s_q.phase == PH_DAT) begin
                            s_d.widx = s_q.widx + 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.shf   <= '1;
            s_q.lclk  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lnk_clk_o = s_q.lclk;
    assign lnk_dat_o = s_q.shf[WORD_W-1];
    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;

endmodule

// File: rtl/ltx_frame_tx_chk.sv
module ltx_frame_tx_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic lnk_clk_o,
    input logic lnk_dat_o
);
    p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (lnk_clk_o && lnk_dat_o));

    p_first_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && !lnk_clk_o));

    p_data_on_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !$stable(lnk_dat_o)) |-> !$stable(lnk_clk_o));

    p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind ltx_frame_tx ltx_frame_tx_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .lnk_clk_o (lnk_clk_o),
    .lnk_dat_o (lnk_dat_o)
);

// File: tb/sim_ltx_frame_tx.sv
module sim_ltx_frame_tx;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  ftype = '0;
    logic [7:0]  udata = '0;
    logic [3:0]  dtag = '0;
    logic [3:0]  ptag = '0;
    logic [3:0]  lm1 = '0;
    logic        ssel = 1'b0;
    logic [7:0]  scrc = '0;
    logic        compat = 1'b0;
    logic [3:0]  baddr;
    logic [15:0] bdata;
    logic        lclk, ldat, busy, done;
    logic [15:0] mem [16];

    int total = 0;
    int bad = 0;
    bit exp_q[$];
    string req_q[$];

    always #5 clk = ~clk;

    assign bdata = mem[baddr];

    ltx_frame_tx #(.DIV(DIV), .WORD_W(16)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ftype_i(ftype),
        .udata_i(udata), .dtag_i(dtag), .ping_tag_i(ptag), .len_m1_i(lm1),
        .sw_crc_sel_i(ssel), .sw_crc_i(scrc), .compat_i(compat),
        .buf_addr_o(baddr), .buf_data_i(bdata), .lnk_clk_o(lclk),
        .lnk_dat_o(ldat), .busy_o(busy), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [15:0] v, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) begin
            exp_q.push_back(v[i]);
            req_q.push_back(req);
        end
    endtask

    function automatic int word_count(input logic [3:0] t, input logic [3:0] l);
        int tbl[8] = '{1, 2, 4, 6, 8, 10, 12, 16};
        if (t == 4'hC) return int'(l) + 1;
        if (t >= 4'h4 && t <= 4'hB) return tbl[t - 4];
        return 0;
    endfunction

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [15:0] w);
        logic [7:0] r;
        r = c;
        for (int b = 1; b >= 0; b--) begin
            r = r ^ w[b*8 +: 8];
            for (int k = 0; k < 8; k++) begin
                r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
            end
        end
        return r;
    endfunction

    // monitor: one comparison per bit, taken in the first cycle of each bit
    initial begin
        int ph;
        int idx;
        ph = 0;
        idx = 0;
        forever begin
            @(negedge clk);
            if (busy) begin
                if (ph == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 extra bit", int'(ldat), 0);
                    end else begin
                        bit    e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        chk(ldat == e, r, int'(ldat), int'(e));
                        chk(lclk == idx[0], "R9 clock level", int'(lclk), idx % 2);
                    end
                    idx++;
                end
                ph = (ph == DIV - 1) ? 0 : ph + 1;
            end else begin
                ph = 0;
                idx = 0;
            end
        end
    end

    task automatic send(input logic [3:0] t, input logic [7:0] ud, input logic [3:0] dt,
                        input logic [3:0] pt, input logic [3:0] l, input bit sel,
                        input logic [7:0] sc, input bit cm, input int seed, input bit disturb);
        int         n;
        logic [7:0] c;
        n = word_count(t, l);
        for (int i = 0; i < 16; i++) mem[i] = 16'(seed * 16'h3B1 + i * 16'h1F35) ^ 16'hA5C3;
        if (!cm) push(16'hF, 4, "R2 opening run");
        push(16'b1001, 4, "R3 start pattern");
        push({12'h0, t}, 4, "R3 type code");
        if (n > 0) begin
            push({8'h0, ud}, 8, "R4 user byte");
            c = 8'h00;
            for (int i = 0; i < n; i++) begin
                push(mem[i], 16, "R4 data word");
                c = crc_ref(c, mem[i]);
            end
            push({8'h0, sel ? sc : c}, 8, "R6 crc byte");
        end
        push({12'h0, (t == 4'h0) ? pt : dt}, 4, (n > 0) ? "R7 tag" : "R5 R7 tag after type");
        push(16'b0110, 4, "R8 end pattern");
        if (!cm) push(16'hF, 4, "R2 closing run");

        ftype = t; udata = ud; dtag = dt; ptag = pt; lm1 = l;
        ssel = sel; scrc = sc; compat = cm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy rises", int'(busy), 1);
        chk(lclk == 1'b0, "R9 first clock level", int'(lclk), 0);
        if (disturb) begin
            repeat (21) @(negedge clk);
            ftype = 4'h0; udata = ~ud; dtag = ~dt; ptag = ~pt; lm1 = 4'hF;
            ssel = ~sel; scrc = ~sc; compat = ~cm; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
        chk(lclk && ldat, "R1 lines high at done", {lclk, ldat}, 3);
        chk(exp_q.size() == 0, "R8 frame length", exp_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        chk(!busy && lclk && ldat, "R1 idle after frame R11 no restart",
            {busy, lclk, ldat}, 3);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lclk && ldat, "R1 lines after reset", {lclk, ldat}, 3);
        chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);

        send(4'h0, 8'h11, 4'h5, 4'hA, 4'h0, 1'b0, 8'h00, 1'b0, 1, 1'b0); // R5 R7 ping
        send(4'h1, 8'h22, 4'h3, 4'hA, 4'h0, 1'b0, 8'h00, 1'b1, 2, 1'b0); // R2 R5 error, compat
        send(4'h4, 8'hC6, 4'h9, 4'h2, 4'h0, 1'b0, 8'h00, 1'b0, 3, 1'b0); // R4 R6 one word
        send(4'h7, 8'h5D, 4'hE, 4'h1, 4'h0, 1'b1, 8'h5A, 1'b0, 4, 1'b1); // R6 sw crc, R11
        send(4'hB, 8'h81, 4'h6, 4'h4, 4'h0, 1'b0, 8'h00, 1'b1, 5, 1'b0); // R4 sixteen words
        send(4'hC, 8'h3C, 4'h7, 4'h8, 4'h2, 1'b0, 8'h00, 1'b0, 6, 1'b0); // R4 variable, 3
        send(4'hC, 8'hF0, 4'hB, 4'h8, 4'h0, 1'b0, 8'h00, 1'b1, 7, 1'b0); // R4 variable, 1
        send(4'hE, 8'h0F, 4'hD, 4'h8, 4'h0, 1'b0, 8'h00, 1'b0, 8, 1'b0); // R5 unused code

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule